// File: doc/BRIEF.md
# Pixel Integration and Double-Sampling Sequencer

This block drives the per-frame control lines of a focal-plane pixel array. Each frame begins by holding the pixel in reset for a fixed interval. A strobe then captures the reset level into one of two reset-level holders, and the two holders take turns from frame to frame. The integration window follows, and its length is programmed in 100 ns units. When the window closes, a strobe captures the integrated level into a third holder. A one-cycle clear pulse then drains residual charge from the follower input, so that the reset level can be read cleanly after the integrated level.

Two operating schedules exist. In the sequential schedule, readout of a frame starts after its integration has ended, and the next frame waits for the readout-done handshake. In the overlapped schedule, the next frame starts at once. The readout of the finished frame is launched as the next integration opens. If that readout has not finished when the next integration would close, the integration window is stretched until it has. A prescaler parameter turns clock cycles into 100 ns ticks. The length setting and the schedule are latched as each frame's reset interval begins.

Top module: `pixtiming_ctrl`

## Requirements
- R1: While reset is held, all strobes, the integration enable and the scan start are low and the frame count reads 0.
- R2: The pixel reset line is high for exactly 2 ticks (2*TICK_DIV clock cycles) before every integration window.
- R3: Exactly one clock cycle separates the fall of pixel reset from the rise of integration enable. In that cycle the odd-frame holder strobe pulses when the frame about to integrate has an odd number (the first frame after reset is number 1), and the even-frame holder strobe pulses otherwise. The two are never high together.
- R4: The integration window lasts N ticks (N*TICK_DIV cycles) for a programmed length N of 1 or more. A programmed length of 0 is clamped to 1 tick.
- R5: The frame count steps by one at the start of each integration, so the first integration cycle of frame n shows count n.
- R6: The integrated-level strobe pulses in the cycle right after integration enable falls, and the clear pulse follows in the next cycle.
- R7: In the sequential schedule (mode input 0), a one-cycle scan start follows the clear pulse. Pixel reset then stays low until readout-done is seen, and it rises in the cycle after that.
- R8: In the overlapped schedule (mode input 1), pixel reset rises in the cycle after the clear pulse. Scan start pulses in the first integration cycle of every frame except the first after reset.
- R9: In the overlapped schedule, if readout-done arrives in integration cycle k while the programmed window is L cycles, integration enable stays high for max(L, k+1) cycles.
- R10: A readout-done pulse while no readout is outstanding has no effect on the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgIntTicks | input | INT_W | Integration length in 100 ns ticks |
| cfgIwr | input | 1 | 1 selects the overlapped schedule, 0 the sequential one |
| scanDone | input | 1 | One-cycle pulse from the readout scanner when a scan finishes |
| pixReset | output | 1 | Pixel reset |
| intEn | output | 1 | Integration enable |
| clrPulse | output | 1 | Follower-node clear pulse |
| shRstOdd | output | 1 | Reset-level holder strobe, odd frames |
| shRstEven | output | 1 | Reset-level holder strobe, even frames |
| shSig | output | 1 | Integrated-level holder strobe |
| scanStart | output | 1 | One-cycle readout scan launch |
| frameCnt | output | FRAME_W | Frames started since reset |

## Verification
The bench goes after the clamp of a zero length. A design without it would run a window of 2^24 ticks or none at all, and the watchdog or the width check catches either. It places readout-done exactly on the last programmed integration cycle and one cycle past it, where an off-by-one in the stall exit stretches or cuts the window by a cycle. It sends readout-done while nothing is outstanding, during sequential integration and in the first overlapped frame; a design that did not ignore it would skip a stall or release a wait early. It also checks the odd/even holder alternation and the lack of a scan launch in the first overlapped frame, where a wrong parity start or a launch with nothing pending shows up at once.

// File: rtl/pixtiming_pkg.sv
package pixtiming_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_RSMP,
    ST_INT,
    ST_STALL,
    ST_SAMP,
    ST_CLR,
    ST_WAIT
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic load;      // latch frame configuration
    logic phaseClr;  // restart tick prescaler and counter
    logic selInt;    // compare against integration target
    logic frameAdv;  // step frame count and parity
  } dpCtl_t;

  // datapath -> control
  typedef struct packed {
    logic phaseDone;
    logic parity;
    logic iwrMode;
  } dpStat_t;

endpackage

// File: rtl/pixtiming_dp.sv
module pixtiming_dp
  import pixtiming_pkg::*;
#(
  parameter int TICK_DIV  = 20,
  parameter int INT_W     = 24,
  parameter int FRAME_W   = 16,
  parameter int RST_TICKS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INT_W-1:0]   cfgIntTicks,
  input  logic               cfgIwr,
  input  dpCtl_t             ctl,
  output dpStat_t            stat,
  output logic [FRAME_W-1:0] frameCnt
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [INT_W-1:0] RST_TGT  = INT_W'(RST_TICKS);

  logic [PRE_W-1:0]   preCnt;
  logic [INT_W-1:0]   tickCnt;
  logic [INT_W-1:0]   intTgt;
  logic [INT_W-1:0]   target;
  logic               iwrQ;
  logic               parity;
  logic [FRAME_W-1:0] frameQ;
  logic               tick;

  assign tick   = (preCnt == PRE_LAST);
  assign target = ctl.selInt ? intTgt : RST_TGT;

  // 100 ns tick prescaler and phase tick counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.phaseClr) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tick) begin
      preCnt  <= '0;
      tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt  <= preCnt + 1'b1;
    end
  end

  // per-frame configuration, zero length clamped to one tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intTgt <= INT_W'(1);
      iwrQ   <= 1'b0;
    end else if (ctl.load) begin
      intTgt <= (cfgIntTicks == '0) ? INT_W'(1) : cfgIntTicks;
      iwrQ   <= cfgIwr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ <= '0;
      parity <= 1'b0;
    end else if (ctl.frameAdv) begin
      frameQ <= frameQ + 1'b1;
      parity <= ~parity;
    end
  end

  assign stat.phaseDone = tick && (tickCnt == target - 1'b1);
  assign stat.parity    = parity;
  assign stat.iwrMode   = iwrQ;
  assign frameCnt       = frameQ;

  // R4: the latched integration target is never zero
  a_r4_target_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (intTgt != '0));

endmodule

// File: rtl/pixtiming_ctl.sv
module pixtiming_ctl
  import pixtiming_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    scanDone,
  output dpCtl_t  ctl,
  output logic    pixReset,
  output logic    intEn,
  output logic    clrPulse,
  output logic    shRstOdd,
  output logic    shRstEven,
  output logic    shSig,
  output logic    scanStart
);

  phase_e state, nxt;
  logic   busy, pending, scanStartQ;
  logic   doneNow, freeNow;
  logic   enterRst, enterInt, startIssue;

  assign doneNow = busy && scanDone;
  assign freeNow = !busy || doneNow;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  nxt = ST_RST;
      ST_RST:   if (stat.phaseDone) nxt = ST_RSMP;
      ST_RSMP:  nxt = ST_INT;
      ST_INT:   if (stat.phaseDone)
                  nxt = (stat.iwrMode && !freeNow) ? ST_STALL : ST_SAMP;
      ST_STALL: if (freeNow) nxt = ST_SAMP;
      ST_SAMP:  nxt = ST_CLR;
      ST_CLR:   nxt = stat.iwrMode ? ST_RST : ST_WAIT;
      ST_WAIT:  if (doneNow) nxt = ST_RST;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign enterRst   = (nxt == ST_RST) && (state != ST_RST);
  assign enterInt   = (nxt == ST_INT) && (state == ST_RSMP);
  assign startIssue = stat.iwrMode ? (enterInt && pending) : (state == ST_CLR);

  assign ctl.load     = enterRst;
  assign ctl.phaseClr = enterRst || enterInt;
  assign ctl.selInt   = (state == ST_INT);
  assign ctl.frameAdv = enterInt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      pending    <= 1'b0;
      scanStartQ <= 1'b0;
    end else begin
      state      <= nxt;
      busy       <= (busy && !scanDone) || startIssue;
      pending    <= (pending && !startIssue) || (state == ST_SAMP && stat.iwrMode);
      scanStartQ <= startIssue;
    end
  end

  assign pixReset  = (state == ST_RST);
  assign shRstOdd  = (state == ST_RSMP) && !stat.parity;
  assign shRstEven = (state == ST_RSMP) &&  stat.parity;
  assign intEn     = (state == ST_INT) || (state == ST_STALL);
  assign shSig     = (state == ST_SAMP);
  assign clrPulse  = (state == ST_CLR);
  assign scanStart = scanStartQ;

  // R3: only one reset-level holder is written per frame
  a_r3_single_holder: assert property (@(posedge clk) disable iff (!rstN)
    !(shRstOdd && shRstEven));

  // R3: a reset-level strobe follows every reset interval
  a_r3_strobe_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pixReset) |-> (shRstOdd || shRstEven));

  // R6: clear pulse directly after the integrated-level strobe
  a_r6_clear_follows: assert property (@(posedge clk) disable iff (!rstN)
    shSig |=> clrPulse);

  // R7: scan start lasts a single cycle
  a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    scanStart |=> !scanStart);

  // R9: the integrated level is never captured while a readout is outstanding
  a_r9_no_sample_busy: assert property (@(posedge clk) disable iff (!rstN)
    shSig |-> !busy);

endmodule

// File: rtl/pixtiming_ctrl.sv
module pixtiming_ctrl
  import pixtiming_pkg::*;
#(
  parameter int TICK_DIV  = 20,
  parameter int INT_W     = 24,
  parameter int FRAME_W   = 16,
  parameter int RST_TICKS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INT_W-1:0]   cfgIntTicks,
  input  logic               cfgIwr,
  input  logic               scanDone,
  output logic               pixReset,
  output logic               intEn,
  output logic               clrPulse,
  output logic               shRstOdd,
  output logic               shRstEven,
  output logic               shSig,
  output logic               scanStart,
  output logic [FRAME_W-1:0] frameCnt
);

  dpCtl_t  ctl;
  dpStat_t stat;

  pixtiming_ctl i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .stat      (stat),
    .scanDone  (scanDone),
    .ctl       (ctl),
    .pixReset  (pixReset),
    .intEn     (intEn),
    .clrPulse  (clrPulse),
    .shRstOdd  (shRstOdd),
    .shRstEven (shRstEven),
    .shSig     (shSig),
    .scanStart (scanStart)
  );

  pixtiming_dp #(
    .TICK_DIV  (TICK_DIV),
    .INT_W     (INT_W),
    .FRAME_W   (FRAME_W),
    .RST_TICKS (RST_TICKS)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cfgIntTicks (cfgIntTicks),
    .cfgIwr      (cfgIwr),
    .ctl         (ctl),
    .stat        (stat),
    .frameCnt    (frameCnt)
  );

  // R5: frame count steps by one as each integration opens
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intEn) |-> (frameCnt == $past(frameCnt) + FRAME_W'(1)));

endmodule

// File: tb/test_pixtiming_ctrl.sv
module test_pixtiming_ctrl;

  localparam int D  = 2;
  localparam int IW = 24;
  localparam int FW = 16;
  localparam int NV = 8;

  // {iwr, lengthTicks[23:0], doneCycle k[15:0], waitDelay[7:0]}
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 24'd0, 16'd1,  8'd3},
    {1'b0, 24'd1, 16'd0,  8'd0},
    {1'b0, 24'd5, 16'd2,  8'd7},
    {1'b1, 24'd3, 16'd2,  8'd0},
    {1'b1, 24'd3, 16'd10, 8'd0},
    {1'b1, 24'd0, 16'd5,  8'd0},
    {1'b1, 24'd4, 16'd7,  8'd0},
    {1'b1, 24'd4, 16'd8,  8'd0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [IW-1:0] cfgIntTicks = '0;
  logic          cfgIwr = 1'b0;
  logic          scanDone = 1'b0;
  logic          pixReset, intEn, clrPulse, shRstOdd, shRstEven, shSig, scanStart;
  logic [FW-1:0] frameCnt;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  pixtiming_ctrl #(.TICK_DIV(D), .INT_W(IW), .FRAME_W(FW), .RST_TICKS(2)) i_pixtiming_ctrl (
    .clk(clk), .rstN(rstN), .cfgIntTicks(cfgIntTicks), .cfgIwr(cfgIwr),
    .scanDone(scanDone), .pixReset(pixReset), .intEn(intEn), .clrPulse(clrPulse),
    .shRstOdd(shRstOdd), .shRstEven(shRstEven), .shSig(shSig),
    .scanStart(scanStart), .frameCnt(frameCnt)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog (R7 R9 wait never released): actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      bit      iwr;
      int      cfg, k, dly, L;
      iwr = VEC[v][48];
      cfg = int'(VEC[v][47:24]);
      k   = int'(VEC[v][23:8]);
      dly = int'(VEC[v][7:0]);
      L   = ((cfg == 0) ? 1 : cfg) * D;

      // R1: reset state, entered from the middle of the previous run
      rstN = 1'b0;
      scanDone = 1'b0;
      cfgIntTicks = IW'(cfg);
      cfgIwr = iwr;
      repeat (3) @(negedge clk);
      check({pixReset, intEn, clrPulse, shRstOdd, shRstEven, shSig, scanStart} == 7'd0,
            "R1 outputs", {pixReset, intEn, clrPulse, shRstOdd, shRstEven, shSig, scanStart}, 0);
      check(frameCnt == 0, "R1 frame count", frameCnt, 0);
      rstN = 1'b1;

      for (int f = 1; f <= 3; f++) begin
        int cnt, expW;
        while (!pixReset) @(negedge clk);
        cnt = 0;
        while (pixReset) begin cnt++; @(negedge clk); end
        check(cnt == 2 * D, "R2 reset width", cnt, 2 * D);
        // R3: one-cycle gap carrying the holder strobe
        check(shRstOdd == f[0] && shRstEven == !f[0] && !intEn, "R3 holder select",
              {intEn, shRstOdd, shRstEven}, f[0] ? 2 : 1);
        @(negedge clk);
        check(intEn == 1'b1, "R3 integration follows strobe", intEn, 1);
        check(frameCnt == FW'(f), "R5 frame count", frameCnt, f);
        check(scanStart == (iwr && f >= 2), iwr ? "R8 scan at integration start" : "R7 no early scan",
              scanStart, (iwr && f >= 2));
        // R4 R9 R10: integration width with a readout-done pulse at cycle k
        cnt = 0;
        while (intEn) begin
          scanDone = (cnt == k);
          cnt++;
          @(negedge clk);
        end
        scanDone = 1'b0;
        expW = (iwr && f >= 2) ? ((k + 1 > L) ? k + 1 : L) : L;
        check(cnt == expW, (iwr && f >= 2) ? "R9 stall width" : "R4 R10 window width", cnt, expW);
        check(shSig && !intEn, "R6 integrated strobe", shSig, 1);
        @(negedge clk);
        check(clrPulse && !shSig, "R6 clear pulse", clrPulse, 1);
        @(negedge clk);
        if (iwr) begin
          check(pixReset && !scanStart, "R8 next frame at once", {pixReset, scanStart}, 2);
        end else begin
          check(scanStart && !pixReset, "R7 scan after clear", {scanStart, pixReset}, 2);
          for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check(!pixReset && !scanStart, "R7 holds for done", {pixReset, scanStart}, 0);
          end
          scanDone = 1'b1;
          @(negedge clk);
          scanDone = 1'b0;
          check(pixReset == 1'b1, "R7 resume after done", pixReset, 1);
        end
      end
    end

    // R10: a stray done right after reset, with nothing outstanding, leaves the
    // sequential schedule waiting for a real handshake
    rstN = 1'b0;
    cfgIwr = 1'b0;
    cfgIntTicks = IW'(1);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    scanDone = 1'b1;
    @(negedge clk);
    scanDone = 1'b0;
    while (!clrPulse) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!pixReset, "R10 stray done ignored", pixReset, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule